// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter and Buffer

This block sits behind a serial ARINC 429 receiver. Each time the receiver has gathered a full 32-bit word, it raises a one-cycle end-of-word strobe together with the word. The filter then rewrites bit 32 of the word with a parity verdict. If label screening is enabled, it looks the word's label up in a small programmable label table. If decode screening is enabled, it compares ARINC bits 9 and 10 against two programmed bits. A word that passes every enabled screen is written into a 32-entry by 32-bit receive buffer. Any other word is dropped.

A host drains the buffer through a 16-bit port, using a select input to choose the lower or upper half of the oldest word. The word is retired only when its upper half is read. The host can watch three flags: data-ready, half-full and full. The label table is written one entry at a time through a small write port.

ARINC bit n maps to `wordIn[n-1]`. The label is bits 1 to 8 (`wordIn[7:0]`), and decode bits 9 and 10 are `wordIn[8]` and `wordIn[9]`.

Top module: `a429_rx_filter`

## Requirements
- R1: The stored word equals the received word except bit 32 (`[31]`). That bit is 0 when the received word, including its own bit 32, has an odd number of ones, and 1 when the count is even.
- R2: With `labelCheckEn`=1, a word whose `wordIn[7:0]` equals one of the 16 label table entries is stored. A word matching no entry is dropped and leaves the buffer unchanged.
- R3: With both screens off (`labelCheckEn`=0, `decodeCheckEn`=0), every strobed word is stored while the buffer is not full.
- R4: With `decodeCheckEn`=1, a word is stored only if `wordIn[9]`==`decodeBits[1]` and `wordIn[8]`==`decodeBits[0]`; otherwise it is dropped.
- R5: With both screens on, a word is stored only if it passes both of them.
- R6: The buffer holds up to 32 words and returns them in arrival order.
- R7: A word that is accepted while the buffer holds 32 words is discarded, and the 32 stored words stay unchanged.
- R8: `rdData` shows bits [15:0] of the oldest word when `halfSel`=0 and bits [31:16] when `halfSel`=1. The oldest word is retired only on a clock edge with `rdStrobe`=1 and `halfSel`=1 while the buffer is not empty; a read of the lower half, or a read of an empty buffer, changes nothing.
- R9: `dataReady`=1 while the buffer holds at least one word, `halfFull`=1 while it holds 16 or more, and `full`=1 while it holds 32.
- R10: After reset the buffer is empty, all three flags are 0, and every label table entry is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordValid | input | 1 | One-cycle end-of-word strobe from the receiver |
| wordIn | input | 32 | Received word, ARINC bit n on `wordIn[n-1]` |
| labelCheckEn | input | 1 | Enable label table screening |
| decodeCheckEn | input | 1 | Enable bits 9/10 screening |
| decodeBits | input | 2 | Expected ARINC bit 10 ([1]) and bit 9 ([0]) |
| labelWrEn | input | 1 | Write one label table entry |
| labelWrAddr | input | 4 | Label table entry index |
| labelWrData | input | 8 | Label value to write |
| rdStrobe | input | 1 | Host read of the half chosen by `halfSel` |
| halfSel | input | 1 | 0 selects bits [15:0], 1 selects bits [31:16] |
| rdData | output | 16 | Selected half of the oldest stored word |
| dataReady | output | 1 | Buffer not empty |
| halfFull | output | 1 | Buffer holds 16 or more words |
| full | output | 1 | Buffer holds 32 words |

## Verification
A word strobed at a clock edge is either written or dropped at that same edge. The flags follow from the buffer count and are therefore valid one edge after the strobe. The bench drives each word on a falling edge, removes it on the next falling edge, and samples the flags after that. `rdData` is combinational from the buffer head, so the bench reads it a short delay after changing `halfSel` and before the rising edge that retires the word. The count-based checks in the bound checker compare one edge after the strobe and its `$past` value.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int LABEL_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;  // write the filtered word at the tail
    logic pop;   // retire the head word
  } fifoCtl_t;
endpackage

// File: rtl/a429_filt_datapath.sv
module a429_filt_datapath
  import a429_filt_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LABELS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoCtl_t                   ctl,
  input  logic [WORD_W-1:0]          wordIn,
  input  logic                       labelWrEn,
  input  logic [$clog2(LABELS)-1:0]  labelWrAddr,
  input  logic [LABEL_W-1:0]         labelWrData,
  input  logic                       halfSel,
  output logic                       labelHit,
  output logic [HALF_W-1:0]          rdData
);
  localparam int PW  = $clog2(DEPTH);
  localparam int LAW = $clog2(LABELS);

  logic [LABELS-1:0] hitVec;

  // Label table: one register per entry, compared in parallel
  for (genvar g = 0; g < LABELS; g++) begin : g_lbl
    logic [LABEL_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entry <= '0;
      else if (labelWrEn && labelWrAddr == LAW'(g)) entry <= labelWrData;
    end
    assign hitVec[g] = (entry == wordIn[LABEL_W-1:0]);
  end
  assign labelHit = |hitVec;

  // Bit 32 carries the parity verdict: 1 for an even count of ones
  logic [WORD_W-1:0] storeWord;
  assign storeWord = {~(^wordIn), wordIn[WORD_W-2:0]};

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= storeWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + PW'(1);
      if (ctl.pop)  rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + PW'(1);
    end
  end

  logic [WORD_W-1:0] headWord;
  assign headWord = mem[rdPtr];
  assign rdData   = halfSel ? headWord[WORD_W-1:HALF_W] : headWord[HALF_W-1:0];
endmodule

// File: rtl/a429_filt_control.sv
module a429_filt_control
  import a429_filt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wordValid,
  input  logic [1:0]    decodePair,
  input  logic          labelCheckEn,
  input  logic          decodeCheckEn,
  input  logic [1:0]    decodeBits,
  input  logic          labelHit,
  input  logic          rdStrobe,
  input  logic          halfSel,
  output fifoCtl_t      ctl,
  output logic [CW-1:0] fifoCount,
  output logic          dataReady,
  output logic          halfFull,
  output logic          full
);
  localparam int HALF_MARK = DEPTH / 2;

  logic labelOk, decodeOk, accept;
  assign labelOk  = !labelCheckEn  || labelHit;
  assign decodeOk = !decodeCheckEn || (decodePair == decodeBits);
  assign accept   = wordValid && labelOk && decodeOk;

  assign ctl.push = accept && !full;
  assign ctl.pop  = rdStrobe && halfSel && dataReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fifoCount <= '0;
    else begin
      unique case ({ctl.push, ctl.pop})
        2'b10:   fifoCount <= fifoCount + CW'(1);
        2'b01:   fifoCount <= fifoCount - CW'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  assign dataReady = (fifoCount != '0);
  assign halfFull  = (fifoCount >= CW'(HALF_MARK));
  assign full      = (fifoCount == CW'(DEPTH));
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_filt_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LABELS = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wordValid,
  input  logic [31:0]               wordIn,
  input  logic                      labelCheckEn,
  input  logic                      decodeCheckEn,
  input  logic [1:0]                decodeBits,
  input  logic                      labelWrEn,
  input  logic [$clog2(LABELS)-1:0] labelWrAddr,
  input  logic [7:0]                labelWrData,
  input  logic                      rdStrobe,
  input  logic                      halfSel,
  output logic [15:0]               rdData,
  output logic                      dataReady,
  output logic                      halfFull,
  output logic                      full
);
  localparam int CW = $clog2(DEPTH+1);

  fifoCtl_t      ctl;
  logic          labelHit;
  logic [CW-1:0] fifoCount;

  a429_filt_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .decodePair(wordIn[9:8]),
    .labelCheckEn(labelCheckEn), .decodeCheckEn(decodeCheckEn),
    .decodeBits(decodeBits), .labelHit(labelHit), .rdStrobe(rdStrobe),
    .halfSel(halfSel), .ctl(ctl), .fifoCount(fifoCount),
    .dataReady(dataReady), .halfFull(halfFull), .full(full)
  );

  a429_filt_datapath #(.DEPTH(DEPTH), .LABELS(LABELS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIn(wordIn),
    .labelWrEn(labelWrEn), .labelWrAddr(labelWrAddr), .labelWrData(labelWrData),
    .halfSel(halfSel), .labelHit(labelHit), .rdData(rdData)
  );
endmodule

// File: rtl/a429_rx_filter_chk.sv
module a429_rx_filter_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          wordValid,
  input logic [31:0]   wordIn,
  input logic          labelCheckEn,
  input logic          decodeCheckEn,
  input logic [1:0]    decodeBits,
  input logic          rdStrobe,
  input logic          halfSel,
  input logic          dataReady,
  input logic          halfFull,
  input logic          full,
  input logic [CW-1:0] fifoCount
);
  // R7: a full buffer stays full until an upper-half read
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    full && !(rdStrobe && halfSel) |=> full);

  // R9: the three flags nest
  p_flag_nesting_r9: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (halfFull && dataReady));

  // R3: with both screens off, a word grows the buffer by one
  p_open_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !labelCheckEn && !decodeCheckEn && !full && !(rdStrobe && halfSel)
    |=> fifoCount == $past(fifoCount) + CW'(1));

  // R4: a decode mismatch never changes the count
  p_decode_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && decodeCheckEn && (wordIn[9:8] != decodeBits) && !(rdStrobe && halfSel)
    |=> fifoCount == $past(fifoCount));

  // R8: a lower-half read does not retire the word
  p_low_read_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !halfSel && !wordValid |=> fifoCount == $past(fifoCount));

  // R8: reading an empty buffer leaves it empty
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady && !wordValid |=> !dataReady);
endmodule

bind a429_rx_filter a429_rx_filter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
  .labelCheckEn(labelCheckEn), .decodeCheckEn(decodeCheckEn),
  .decodeBits(decodeBits), .rdStrobe(rdStrobe), .halfSel(halfSel),
  .dataReady(dataReady), .halfFull(halfFull), .full(full),
  .fifoCount(fifoCount)
);

// File: tb/a429_rx_filter_tb.sv
module a429_rx_filter_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wordValid = 0;
  logic [31:0] wordIn = '0;
  logic        labelCheckEn = 0, decodeCheckEn = 0;
  logic [1:0]  decodeBits = '0;
  logic        labelWrEn = 0;
  logic [3:0]  labelWrAddr = '0;
  logic [7:0]  labelWrData = '0;
  logic        rdStrobe = 0, halfSel = 0;
  logic [15:0] rdData;
  logic        dataReady, halfFull, full;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  a429_rx_filter u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .labelCheckEn(labelCheckEn), .decodeCheckEn(decodeCheckEn),
    .decodeBits(decodeBits), .labelWrEn(labelWrEn), .labelWrAddr(labelWrAddr),
    .labelWrData(labelWrData), .rdStrobe(rdStrobe), .halfSel(halfSel),
    .rdData(rdData), .dataReady(dataReady), .halfFull(halfFull), .full(full)
  );

  // Expected stored form per R1
  function automatic logic [31:0] expStore(input logic [31:0] w);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += int'(w[i]);
    return {((ones % 2) == 0) ? 1'b1 : 1'b0, w[30:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); wordValid = 1; wordIn = w;
    @(negedge clk); wordValid = 0;
  endtask

  task automatic readWord(output logic [31:0] w);
    @(negedge clk); rdStrobe = 1; halfSel = 0; #1 w[15:0] = rdData;
    @(negedge clk); halfSel = 1; #1 w[31:16] = rdData;
    @(negedge clk); rdStrobe = 0; halfSel = 0;
  endtask

  task automatic progLabel(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); labelWrEn = 1; labelWrAddr = a; labelWrData = d;
    @(negedge clk); labelWrEn = 0;
  endtask

  // {labelEn, decodeEn, decodeBits[1:0], expectStored, word[31:0]}
  localparam logic [36:0] VEC [10] = '{
    {1'b0, 1'b0, 2'b00, 1'b1, 32'h1234_5631},  // R3 no screens
    {1'b1, 1'b0, 2'b00, 1'b0, 32'h1234_5631},  // R2 label miss
    {1'b1, 1'b0, 2'b00, 1'b1, 32'h0000_0030},  // R2 hit entry 0
    {1'b1, 1'b0, 2'b00, 1'b1, 32'hFFFF_FFA1},  // R2 hit entry 5
    {1'b0, 1'b1, 2'b10, 1'b1, 32'h0000_0200},  // R4 match
    {1'b0, 1'b1, 2'b01, 1'b0, 32'h0000_0200},  // R4 mismatch
    {1'b1, 1'b1, 2'b00, 1'b1, 32'h0000_000F},  // R5 both pass
    {1'b1, 1'b1, 2'b00, 1'b0, 32'h0000_0031},  // R5 label fails
    {1'b1, 1'b1, 2'b11, 1'b1, 32'h0000_030F},  // R5 both pass
    {1'b1, 1'b1, 2'b11, 1'b0, 32'h0000_010F}   // R5 decode fails
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, w;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(!dataReady && !halfFull && !full, "R10 flags after reset",
          {29'd0, dataReady, halfFull, full}, 32'd0);
    // R10: cleared table matches label 00
    labelCheckEn = 1;
    sendWord(32'h0000_5500);
    check(dataReady, "R10 label table cleared", {31'd0, dataReady}, 32'd1);
    readWord(got);
    check(got == expStore(32'h0000_5500), "R1 stored word", got, expStore(32'h0000_5500));
    labelCheckEn = 0;

    progLabel(4'd0, 8'h30);
    progLabel(4'd5, 8'hA1);
    progLabel(4'd15, 8'h0F);
    for (int i = 0; i < 16; i++) if (i != 0 && i != 5 && i != 15) progLabel(4'(i), 8'hEE);

    foreach (VEC[i]) begin
      labelCheckEn  = VEC[i][36];
      decodeCheckEn = VEC[i][35];
      decodeBits    = VEC[i][34:33];
      sendWord(VEC[i][31:0]);
      check(dataReady == VEC[i][32], "R2/R3/R4/R5 screening decision",
            {31'd0, dataReady}, {31'd0, VEC[i][32]});
      if (VEC[i][32]) begin
        readWord(got);
        check(got == expStore(VEC[i][31:0]), "R1 parity bit in stored word", got, expStore(VEC[i][31:0]));
      end
    end
    labelCheckEn = 0; decodeCheckEn = 0;

    // R1 corner values
    sendWord(32'h0000_0000); readWord(got);
    check(got == 32'h8000_0000, "R1 zero word", got, 32'h8000_0000);
    sendWord(32'h8000_0000); readWord(got);
    check(got == 32'h0000_0000, "R1 single one", got, 32'h0000_0000);

    // R8 empty read ignored
    readWord(got);
    check(!dataReady, "R8 empty read", {31'd0, dataReady}, 32'd0);
    sendWord(32'hCAFE_0123); readWord(got);
    check(got == expStore(32'hCAFE_0123), "R8 word after empty read", got, expStore(32'hCAFE_0123));

    // R9/R6 fill
    for (int i = 0; i < 32; i++) begin
      sendWord(32'hA500_0000 ^ (i << 8) ^ i);
      if (i == 14) check(!halfFull, "R9 15 words not half-full", {31'd0, halfFull}, 32'd0);
      if (i == 15) check(halfFull, "R9 16 words half-full", {31'd0, halfFull}, 32'd1);
      if (i == 30) check(!full, "R9 31 words not full", {31'd0, full}, 32'd0);
    end
    check(full && halfFull && dataReady, "R9 full flags",
          {29'd0, dataReady, halfFull, full}, 32'd7);
    // R7 overflow discarded
    sendWord(32'hDEAD_BEEF);
    check(full, "R7 still full", {31'd0, full}, 32'd1);
    // R8 lower-half read alone does not retire
    @(negedge clk); rdStrobe = 1; halfSel = 0;
    @(negedge clk); rdStrobe = 0;
    check(full, "R8 lower read keeps word", {31'd0, full}, 32'd1);
    #1 check(rdData == expStore(32'hA500_0000)  [15:0], "R8 lower half", {16'd0, rdData},
             {16'd0, expStore(32'hA500_0000) [15:0]});
    for (int i = 0; i < 32; i++) begin
      w = 32'hA500_0000 ^ (i << 8) ^ i;
      readWord(got);
      check(got == expStore(w), "R6 order / R7 contents unchanged", got, expStore(w));
    end
    check(!dataReady, "R9 empty after drain", {31'd0, dataReady}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule